// File: doc/BRIEF.md
# Stream Configuration Entry Decoder

This block judges a pair of configuration entries for an I/O memory management unit and turns them into one translation decision. A 512-bit stream table entry and a 512-bit context descriptor are presented together with a global enable, a global-bypass abort bit and a select that picks one of the two page-table bases of the context descriptor. The block returns a translation status, the stage-1 and stage-2 enables, the physical address width and the log2 translation granule.

A request is accepted on an `in_valid` pulse. Only the fields the decision needs are captured. The decoded result appears one cycle after capture, together with a one-cycle `out_valid` pulse, and stays on the outputs until the next result. Memory fetches, table walks and caching are done elsewhere; this block only decodes entries already held in registers.

Status codes are DISABLE=0, ABORT=1, BYPASS=2, ERROR=3 and SUCCESS=4. Vector bit `32*k+b` holds bit `b` of word `k` of an entry.

Top module: `scfg_decoder`

## Requirements
- R1: With `glb_enable` low the status is DISABLE (0), or ABORT (1) when `glb_abort` is high, whatever the entries hold.
- R2: With `glb_enable` high and the stream valid bit (stream bit 0) low, the status is ERROR (3).
- R3: For a valid stream, the 3-bit config field in stream bits 3:1 gives ABORT (1) when its bit 2 is clear and BYPASS (2) when it equals exactly 4.
- R4: For config 5 or 7 (stage 1 on), the status is ERROR (3) when the context valid bit (context bit 31) is clear or the selected granule is invalid, and SUCCESS (4) otherwise. Config 6 (stage 2 only) gives SUCCESS without looking at the context descriptor.
- R5: `s1_en` equals config bit 0 and `s2_en` equals config bit 1 when the status is SUCCESS; both are 0 for any other status.
- R6: `pa_bits` comes from the size code in stream bits 178:176 clamped to at most 4, mapped 0..5 to 32, 36, 40, 42, 44, 48; when stream bit 179 (64-bit format) is clear it is 40.
- R7: The granule code for base `sel` is context bits 16*sel+7:16*sel+6. Base 0 maps 0,1,2,3 to 12, 16, 14, 0; base 1 maps them to 0, 14, 12, 16. 0 means invalid.
- R8: `tsz` is context bits 16*sel+5:16*sel, `walk_dis` is context bit 16*sel+14, and `asid` is context bits 63:48, for every status.
- R9: An `in_valid` sampled at edge N gives the result after edge N+1 with `out_valid` high for exactly that one cycle; `out_valid` is low otherwise.
- R10: Outputs hold between results; input changes without `in_valid` have no effect.
- R11: After reset `out_valid` is 0, status is DISABLE and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request pulse; captures the inputs |
| ste_entry | input | 512 | Stream table entry |
| cd_entry | input | 512 | Context descriptor |
| glb_enable | input | 1 | Global translation enable |
| glb_abort | input | 1 | Abort instead of pass when globally disabled |
| tt_sel | input | 1 | Page-table base select |
| out_valid | output | 1 | One-cycle result pulse |
| status | output | 3 | Translation status code |
| s1_en | output | 1 | Stage-1 translation enabled |
| s2_en | output | 1 | Stage-2 translation enabled |
| pa_bits | output | 6 | Physical address width in bits |
| granule | output | 5 | log2 granule size, 0 when invalid |
| tsz | output | 6 | Table size field of the selected base |
| walk_dis | output | 1 | Walk-disable bit of the selected base |
| asid | output | 16 | Address space identifier |

## Verification
The hardest situation to reach is the one where every earlier check passes and only the granule decides: a valid stream with stage 1 on, a valid context descriptor, and a granule code that is legal for one base but invalid for the other. The stimulus places different codes in the two halves of context word 0 and flips `tt_sel` between requests with otherwise identical entries, so ERROR and SUCCESS differ only through the asymmetric table. Size codes above the clamp and a cleared 64-bit-format bit are swept as well, and inputs are scrambled between requests to show the held result does not move.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 16;
  localparam int ENTRY_W     = WORD_W * ENTRY_WORDS;

  localparam int CFG_W   = 3;
  localparam int PS_W    = 3;
  localparam int PA_W    = 6;
  localparam int GRAN_W  = 5;
  localparam int TSZ_W   = 6;
  localparam int TG_W    = 2;
  localparam int ASID_W  = 16;
  localparam int HALF_W  = 16;
  localparam int TG_OFF  = 6;
  localparam int EPD_OFF = 14;
  localparam int NUM_BASES = 2;

  // stream entry field positions
  localparam int STE_VALID_BIT = 0;
  localparam int STE_CFG_LSB   = 1;
  localparam int STE_PS_LSB    = 5 * WORD_W + 16;
  localparam int STE_AA64_BIT  = 5 * WORD_W + 19;
  // context descriptor field positions
  localparam int CD_VALID_BIT  = 31;
  localparam int CD_ASID_LSB   = WORD_W + 16;

  localparam logic [PS_W-1:0] MAX_OAS_CODE = 3'd4;
  localparam logic [PA_W-1:0] LEGACY_PA    = 6'd40;

  typedef enum logic [2:0] {
    ST_DISABLE = 3'd0,
    ST_ABORT   = 3'd1,
    ST_BYPASS  = 3'd2,
    ST_ERROR   = 3'd3,
    ST_SUCCESS = 3'd4
  } scfg_status_e;

  function automatic logic [PA_W-1:0] oas_width(input logic [PS_W-1:0] code);
    logic [PA_W-1:0] w;
    case (code)
      3'd0:    w = 6'd32;
      3'd1:    w = 6'd36;
      3'd2:    w = 6'd40;
      3'd3:    w = 6'd42;
      3'd4:    w = 6'd44;
      3'd5:    w = 6'd48;
      default: w = 6'd0;
    endcase
    return w;
  endfunction

  function automatic logic [GRAN_W-1:0] gran_log2(input logic [TG_W-1:0] code,
                                                  input logic base);
    logic [GRAN_W-1:0] g;
    case ({base, code})
      3'b0_00: g = 5'd12;
      3'b0_01: g = 5'd16;
      3'b0_10: g = 5'd14;
      3'b0_11: g = 5'd0;
      3'b1_00: g = 5'd0;
      3'b1_01: g = 5'd14;
      3'b1_10: g = 5'd12;
      default: g = 5'd16;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/scfg_stream_decode.sv
module scfg_stream_decode
  import scfg_pkg::*;
#(
  parameter int P_CFG_W = CFG_W,
  parameter int P_PS_W  = PS_W,
  parameter int P_PA_W  = PA_W
) (
  input  logic              ste_valid,
  input  logic [P_CFG_W-1:0] cfg,
  input  logic [P_PS_W-1:0]  ps_code,
  input  logic              aa64,
  output logic              ste_bad,
  output logic              cfg_abort,
  output logic              cfg_bypass,
  output logic              s1_req,
  output logic              s2_req,
  output logic [P_PA_W-1:0] pa_width
);
  localparam logic [P_CFG_W-1:0] BYPASS_CODE = P_CFG_W'(4);

  logic [P_PS_W-1:0] ps_clamped;

  always_comb begin
    ste_bad    = !ste_valid;
    cfg_abort  = !cfg[2];
    cfg_bypass = (cfg == BYPASS_CODE);
    s1_req     = cfg[0];
    s2_req     = cfg[1];
  end

  always_comb begin
    ps_clamped = (ps_code > MAX_OAS_CODE) ? MAX_OAS_CODE : ps_code;
    if (!aa64) pa_width = LEGACY_PA;
    else       pa_width = oas_width(ps_clamped);
  end
endmodule

// File: rtl/scfg_ctx_decode.sv
module scfg_ctx_decode
  import scfg_pkg::*;
#(
  parameter int P_BASES = NUM_BASES,
  parameter int P_HALF  = HALF_W
) (
  input  logic [WORD_W-1:0] ctl_word,
  input  logic              sel,
  output logic [TSZ_W-1:0]  tsz_sel,
  output logic [GRAN_W-1:0] gran_sel,
  output logic              epd_sel
);
  logic [TSZ_W-1:0]  tsz_a  [P_BASES];
  logic [GRAN_W-1:0] gran_a [P_BASES];
  logic              epd_a  [P_BASES];

  for (genvar b = 0; b < P_BASES; b++) begin : g_base
    logic [TG_W-1:0] tg_code;
    assign tsz_a[b]  = ctl_word[b*P_HALF +: TSZ_W];
    assign tg_code   = ctl_word[b*P_HALF+TG_OFF +: TG_W];
    assign epd_a[b]  = ctl_word[b*P_HALF+EPD_OFF];
    assign gran_a[b] = gran_log2(tg_code, 1'(b));
  end

  always_comb begin
    tsz_sel  = tsz_a[sel];
    gran_sel = gran_a[sel];
    epd_sel  = epd_a[sel];
  end

  logic unused_ctl;
  assign unused_ctl = ^ctl_word;
endmodule

// File: rtl/scfg_status_arb.sv
module scfg_status_arb
  import scfg_pkg::*;
(
  input  logic              glb_enable,
  input  logic              glb_abort,
  input  logic              ste_bad,
  input  logic              cfg_abort,
  input  logic              cfg_bypass,
  input  logic              s1_req,
  input  logic              s2_req,
  input  logic              cd_valid,
  input  logic [GRAN_W-1:0] gran,
  output scfg_status_e      status,
  output logic              s1_on,
  output logic              s2_on
);
  always_comb begin
    if (!glb_enable)      status = glb_abort ? ST_ABORT : ST_DISABLE;
    else if (ste_bad)     status = ST_ERROR;
    else if (cfg_abort)   status = ST_ABORT;
    else if (cfg_bypass)  status = ST_BYPASS;
    else if (s1_req && (!cd_valid || gran == '0)) status = ST_ERROR;
    else                  status = ST_SUCCESS;
  end

  always_comb begin
    s1_on = (status == ST_SUCCESS) && s1_req;
    s2_on = (status == ST_SUCCESS) && s2_req;
  end
endmodule

// File: rtl/scfg_decoder.sv
module scfg_decoder
  import scfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [ENTRY_W-1:0] ste_entry,
  input  logic [ENTRY_W-1:0] cd_entry,
  input  logic               glb_enable,
  input  logic               glb_abort,
  input  logic               tt_sel,
  output logic               out_valid,
  output logic [2:0]         status,
  output logic               s1_en,
  output logic               s2_en,
  output logic [PA_W-1:0]    pa_bits,
  output logic [GRAN_W-1:0]  granule,
  output logic [TSZ_W-1:0]   tsz,
  output logic               walk_dis,
  output logic [ASID_W-1:0]  asid
);
  // capture stage: only the fields the decision uses
  logic               req_q;
  logic               en_q, ab_q, sel_q;
  logic               ste_v_q, aa64_q;
  logic [CFG_W-1:0]   cfg_q;
  logic [PS_W-1:0]    ps_q;
  logic [WORD_W-1:0]  ctl_q;
  logic [ASID_W-1:0]  asid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      en_q    <= 1'b0;
      ab_q    <= 1'b0;
      sel_q   <= 1'b0;
      ste_v_q <= 1'b0;
      aa64_q  <= 1'b0;
      cfg_q   <= '0;
      ps_q    <= '0;
      ctl_q   <= '0;
      asid_q  <= '0;
    end else begin
      req_q <= in_valid;
      if (in_valid) begin
        en_q    <= glb_enable;
        ab_q    <= glb_abort;
        sel_q   <= tt_sel;
        ste_v_q <= ste_entry[STE_VALID_BIT];
        cfg_q   <= ste_entry[STE_CFG_LSB +: CFG_W];
        ps_q    <= ste_entry[STE_PS_LSB +: PS_W];
        aa64_q  <= ste_entry[STE_AA64_BIT];
        ctl_q   <= cd_entry[0 +: WORD_W];
        asid_q  <= cd_entry[CD_ASID_LSB +: ASID_W];
      end
    end
  end

  logic unused_in;
  assign unused_in = ^{ste_entry, cd_entry};

  // decode
  logic              ste_bad, cfg_abort, cfg_bypass, s1_req, s2_req;
  logic [PA_W-1:0]   pa_d;
  logic [TSZ_W-1:0]  tsz_d;
  logic [GRAN_W-1:0] gran_d;
  logic              epd_d;
  scfg_status_e      status_d;
  logic              s1_d, s2_d;

  scfg_stream_decode u_stream (
    .ste_valid (ste_v_q),
    .cfg       (cfg_q),
    .ps_code   (ps_q),
    .aa64      (aa64_q),
    .ste_bad   (ste_bad),
    .cfg_abort (cfg_abort),
    .cfg_bypass(cfg_bypass),
    .s1_req    (s1_req),
    .s2_req    (s2_req),
    .pa_width  (pa_d)
  );

  scfg_ctx_decode u_ctx (
    .ctl_word(ctl_q),
    .sel     (sel_q),
    .tsz_sel (tsz_d),
    .gran_sel(gran_d),
    .epd_sel (epd_d)
  );

  scfg_status_arb u_arb (
    .glb_enable(en_q),
    .glb_abort (ab_q),
    .ste_bad   (ste_bad),
    .cfg_abort (cfg_abort),
    .cfg_bypass(cfg_bypass),
    .s1_req    (s1_req),
    .s2_req    (s2_req),
    .cd_valid  (ctl_q[CD_VALID_BIT]),
    .gran      (gran_d),
    .status    (status_d),
    .s1_on     (s1_d),
    .s2_on     (s2_d)
  );

  // result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      status    <= ST_DISABLE;
      s1_en     <= 1'b0;
      s2_en     <= 1'b0;
      pa_bits   <= '0;
      granule   <= '0;
      tsz       <= '0;
      walk_dis  <= 1'b0;
      asid      <= '0;
    end else begin
      out_valid <= req_q;
      if (req_q) begin
        status   <= status_d;
        s1_en    <= s1_d;
        s2_en    <= s2_d;
        pa_bits  <= pa_d;
        granule  <= gran_d;
        tsz      <= tsz_d;
        walk_dis <= epd_d;
        asid     <= asid_q;
      end
    end
  end
endmodule

// File: rtl/scfg_decoder_chk.sv
module scfg_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       out_valid,
  input logic [2:0] status,
  input logic       s1_en,
  input logic       s2_en,
  input logic [5:0] pa_bits,
  input logic [4:0] granule,
  input logic [5:0] tsz,
  input logic       walk_dis
);
  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  assert_no_stray_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  assert_status_range_R1: assert property (@(posedge clk) disable iff (rst)
    status <= 3'd4);

  assert_stage_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (s1_en || s2_en) |-> status == 3'd4);

  assert_s1_granule_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && s1_en) |-> granule != 5'd0);

  assert_pa_legal_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pa_bits == 6'd32 || pa_bits == 6'd36 || pa_bits == 6'd40 ||
                   pa_bits == 6'd42 || pa_bits == 6'd44));

  assert_gran_legal_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (granule == 5'd0 || granule == 5'd12 ||
                   granule == 5'd14 || granule == 5'd16));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(status) && $stable(pa_bits) && $stable(granule) &&
                    $stable(tsz) && $stable(walk_dis) && $stable(s1_en)));
endmodule

bind scfg_decoder scfg_decoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .status   (status),
  .s1_en    (s1_en),
  .s2_en    (s2_en),
  .pa_bits  (pa_bits),
  .granule  (granule),
  .tsz      (tsz),
  .walk_dis (walk_dis)
);

// File: tb/tb_scfg_decoder.sv
module tb_scfg_decoder;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [511:0] ste_entry, cd_entry;
  logic         glb_enable, glb_abort, tt_sel;
  logic         out_valid;
  logic [2:0]   status;
  logic         s1_en, s2_en;
  logic [5:0]   pa_bits;
  logic [4:0]   granule;
  logic [5:0]   tsz;
  logic         walk_dis;
  logic [15:0]  asid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scfg_decoder dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [511:0] mk_ste(input bit v, input bit [2:0] cfg,
                                          input bit [2:0] ps, input bit aa64);
    logic [511:0] s = '0;
    s[0] = v; s[3:1] = cfg; s[178:176] = ps; s[179] = aa64;
    s[40] = 1'b1; s[300] = 1'b1;  // unrelated bits
    return s;
  endfunction

  function automatic logic [511:0] mk_cd(input bit v, input bit [15:0] id,
      input bit [1:0] tg0, input bit [1:0] tg1, input bit [5:0] sz0,
      input bit [5:0] sz1, input bit e0, input bit e1);
    logic [511:0] c = '0;
    c[5:0] = sz0; c[7:6] = tg0; c[14] = e0;
    c[21:16] = sz1; c[23:22] = tg1; c[30] = e1;
    c[31] = v; c[63:48] = id; c[200] = 1'b1;
    return c;
  endfunction

  // expected values from the requirements
  function automatic int e_gran(input bit [1:0] tg, input bit sel);
    if (!sel) return (tg == 0) ? 12 : (tg == 1) ? 16 : (tg == 2) ? 14 : 0;
    return (tg == 0) ? 0 : (tg == 1) ? 14 : (tg == 2) ? 12 : 16;
  endfunction

  function automatic int e_pa(input bit [2:0] ps, input bit aa64);
    int c;
    if (!aa64) return 40;
    c = (ps > 4) ? 4 : ps;
    case (c) 0: return 32; 1: return 36; 2: return 40; 3: return 42; default: return 44; endcase
  endfunction

  function automatic int e_status(input bit en, input bit ab, input bit sv,
      input bit [2:0] cfg, input bit cv, input int g);
    if (!en) return ab ? 1 : 0;
    if (!sv) return 3;
    if (!cfg[2]) return 1;
    if (cfg == 4) return 2;
    if (cfg[0] && (!cv || g == 0)) return 3;
    return 4;
  endfunction

  // issue one request, then check out_valid timing and all outputs
  task automatic run(input string tag, input bit en, input bit ab, input bit sv,
      input bit [2:0] cfg, input bit [2:0] ps, input bit aa64, input bit cv,
      input bit [15:0] id, input bit [1:0] tg0, input bit [1:0] tg1,
      input bit [5:0] sz0, input bit [5:0] sz1, input bit e0, input bit e1,
      input bit sel);
    int g, st;
    g  = e_gran(sel ? tg1 : tg0, sel);
    st = e_status(en, ab, sv, cfg, cv, g);
    @(negedge clk);
    ste_entry = mk_ste(sv, cfg, ps, aa64);
    cd_entry  = mk_cd(cv, id, tg0, tg1, sz0, sz1, e0, e1);
    glb_enable = en; glb_abort = ab; tt_sel = sel; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R9 no early pulse"}, out_valid, 0);
    @(negedge clk);
    check({tag, " R9 pulse"}, out_valid, 1);
    check({tag, " status R1-chain"}, status, st);
    check({tag, " R5 s1_en"}, s1_en, (st == 4) ? cfg[0] : 0);
    check({tag, " R5 s2_en"}, s2_en, (st == 4) ? cfg[1] : 0);
    check({tag, " R6 pa_bits"}, pa_bits, e_pa(ps, aa64));
    check({tag, " R7 granule"}, granule, g);
    check({tag, " R8 tsz"}, tsz, sel ? sz1 : sz0);
    check({tag, " R8 walk_dis"}, walk_dis, sel ? e1 : e0);
    check({tag, " R8 asid"}, asid, id);
  endtask

  task automatic t_reset;
    check("R11 out_valid", out_valid, 0);
    check("R11 status", status, 0);
    check("R11 pa_bits", pa_bits, 0);
    check("R11 granule", granule, 0);
    check("R11 s1_en", s1_en, 0);
    check("R11 asid", asid, 0);
  endtask

  task automatic t_global;  // R1
    run("R1 disable", 0, 0, 1, 3'd5, 3'd2, 1, 1, 16'h1111, 2'd0, 2'd1, 6'd3, 6'd4, 0, 0, 0);
    run("R1 abort",   0, 1, 0, 3'd0, 3'd2, 1, 0, 16'h2222, 2'd3, 2'd0, 6'd3, 6'd4, 0, 0, 1);
  endtask

  task automatic t_ste;  // R2, R3
    run("R2 invalid ste", 1, 0, 0, 3'd5, 3'd1, 1, 1, 16'h0001, 2'd0, 2'd1, 6'd1, 6'd2, 0, 0, 0);
    for (int c = 0; c < 4; c++)
      run("R3 abort cfg", 1, 1, 1, 3'(c), 3'd1, 1, 1, 16'h0002, 2'd0, 2'd1, 6'd1, 6'd2, 0, 0, 0);
    run("R3 bypass", 1, 0, 1, 3'd4, 3'd3, 1, 0, 16'h0003, 2'd3, 2'd0, 6'd1, 6'd2, 1, 1, 0);
  endtask

  task automatic t_stage1;  // R4, R5, R7 granule asymmetry
    for (int s = 0; s < 2; s++)
      for (int t = 0; t < 4; t++)
        run("R7 gran sweep", 1, 0, 1, 3'd5, 3'd4, 1, 1, 16'hBEEF, 2'(t), 2'(3 - t),
            6'd25, 6'd39, 1, 0, s[0]);
    run("R4 cd invalid", 1, 0, 1, 3'd5, 3'd0, 1, 0, 16'h0004, 2'd0, 2'd3, 6'd1, 6'd2, 0, 0, 0);
    run("R4 s2 only", 1, 0, 1, 3'd6, 3'd0, 1, 0, 16'h0005, 2'd3, 2'd0, 6'd1, 6'd2, 0, 1, 0);
    run("R4 both",    1, 0, 1, 3'd7, 3'd2, 1, 1, 16'h0006, 2'd2, 2'd3, 6'd9, 6'd10, 0, 1, 1);
    run("R4 both bad gran", 1, 0, 1, 3'd7, 3'd2, 1, 1, 16'h0007, 2'd2, 2'd0, 6'd9, 6'd10, 0, 1, 1);
  endtask

  task automatic t_pa;  // R6
    for (int p = 0; p < 8; p++)
      run("R6 size", 1, 0, 1, 3'd6, 3'(p), 1, 1, 16'h0010, 2'd0, 2'd1, 6'd1, 6'd2, 0, 0, 0);
    run("R6 legacy", 1, 0, 1, 3'd6, 3'd0, 0, 1, 16'h0011, 2'd0, 2'd1, 6'd1, 6'd2, 0, 0, 0);
  endtask

  task automatic t_hold;  // R10
    run("R10 base", 1, 0, 1, 3'd5, 3'd3, 1, 1, 16'hA5A5, 2'd1, 2'd1, 6'd17, 6'd18, 1, 0, 0);
    @(negedge clk);
    ste_entry = '0; cd_entry = '1; glb_enable = 0; glb_abort = 1; tt_sel = 1;
    repeat (3) @(negedge clk);
    check("R10 out_valid low", out_valid, 0);
    check("R10 status held", status, 4);
    check("R10 granule held", granule, 16);
    check("R10 pa held", pa_bits, 42);
    check("R10 tsz held", tsz, 17);
    check("R10 asid held", asid, 16'hA5A5);
  endtask

  initial begin
    rst = 1'b1; in_valid = 0; ste_entry = '0; cd_entry = '0;
    glb_enable = 0; glb_abort = 0; tt_sel = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_global();
    t_ste();
    t_stage1();
    t_pa();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule